// File: doc/BRIEF.md
# Configurable Four-Macrocell Logic Block

This block models one logic block of a small programmable device. Eighteen logic inputs feed a programmable AND array. Its product terms are combined into sums, and each sum can be XORed with a further term. The results drive four macrocells. Each macrocell either passes its sum straight to its output or captures it in a register. The register clock is chosen once for the whole block. It can be one of three global clock lines, or a clock built from a product term inside the block. Three control terms give a register reset, an output-enable signal and the clock just mentioned.

All inputs are sampled on one system clock. A global clock line, or the product-term clock, counts as firing when it is seen high in a cycle after being low. Configuration is written one row at a time. A row is taken only while the load strobe is high. The block keeps its configuration when the global register reset is used; only the block reset clears it.

Top module: `glb_block`

## Requirements
- R1: Row p (0..22) holds the fuses of product term p. Bit 2i includes input i, and bit 2i+1 includes the complement of input i. The term is the AND of its included literals. A row with no fuse set gives 0.
- R2: In bypass mode (mode bit 1 = 0), the data value of macrocell m is the OR of terms 4m..4m+3.
- R3: In wide mode (mode bit 1 = 1), the data value of macrocell m is formed in two steps. First, take the OR of the four-term groups k whose share bit k is set (mode bits 5:2). Then XOR that with term 16+m.
- R4: With mode bit 0 = 0, output m shows its data value in the same cycle. With mode bit 0 = 1, output m shows the macrocell register.
- R5: Clock select (mode row bits 25:24) has four settings. Values 0, 1 and 2 pick global clock line 0, 1 or 2, and value 3 picks term 20. A register loads its data value at the first system clock edge at which the selected source is high after having been low. Holding the source high, or firing any unselected source, leaves the register unchanged.
- R6: grst_n low at a clock edge clears every macrocell register, even if a load would also occur at that edge. Configuration is kept.
- R7: Term 21 high at a clock edge clears every macrocell register, and this reset wins over a load.
- R8: pt_oe equals product term 22.
- R9: A write with cfg_load high and cfg_addr 0..22 replaces that row, and cfg_addr 23 replaces the mode row. Mode bits for macrocell m lie at 6m..6m+5, in this order from the low end: the register bit, the wide bit, then four share bits. Writes with cfg_load low, and addresses 24..31, change nothing.
- R10: rst_n low at a clock edge clears all rows, the mode row and the registers, after which all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| grst_n | input | 1 | Synchronous active-low global register reset |
| cfg_load | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Row address of the write |
| cfg_data | input | 36 | Row contents |
| gclk | input | 3 | Global clock lines, sampled on clk |
| lgc_in | input | 18 | Logic inputs |
| mc_out | output | 4 | Macrocell outputs |
| pt_oe | output | 1 | Output-enable product term |

## Verification
The hardest situations to reach are those where register loading meets the control terms. One is a clock edge that arrives from a product term. Another is such an edge landing in the same cycle as a reset term. A third is a source held high across several data changes. The stimulus reaches them by programming the clock term and the reset term onto spare inputs. It then raises the clock input together with reset, and holds it high while the data input flips. Random configurations with sparse fuses and random share masks exercise the array and the sum paths. A programmed counter and a decoder give long, directed sequences.

// File: rtl/glb_pkg.sv
// Package glb_pkg: sizes and row layout shared by the logic block.
// Assumes the mode row fits inside one configuration row.
package glb_pkg;
    localparam int N_IN      = 18;
    localparam int N_MC      = 4;
    localparam int PT_PER_MC = 4;
    localparam int N_GCLK    = 3;
    localparam int ROW_W     = 2 * N_IN;
    localparam int N_DATA_PT = N_MC * PT_PER_MC;
    localparam int XOR_PT0   = N_DATA_PT;
    localparam int CLK_PT    = XOR_PT0 + N_MC;
    localparam int RST_PT    = CLK_PT + 1;
    localparam int OE_PT     = RST_PT + 1;
    localparam int N_PT      = OE_PT + 1;
    localparam int MODE_ROW  = N_PT;
    localparam int ADDR_W    = $clog2(N_PT + 1);
    localparam int MC_MODE_W = 2 + N_MC;
    localparam int CSEL_W    = 2;
    localparam int CSEL_LSB  = N_MC * MC_MODE_W;
    localparam int MODE_USED = CSEL_LSB + CSEL_W;

    typedef struct packed {
        logic [N_MC-1:0] share;
        logic            wide;
        logic            reg_en;
    } mc_mode_t;
endpackage

// File: rtl/glb_cfg_store.sv
// Module glb_cfg_store: holds the fuse rows and the mode row.
// Rows are written one per cycle while cfg_load is high.
// Assumes a synchronous active-low reset clears every row.
module glb_cfg_store
    import glb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_load,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [ROW_W-1:0]              cfg_data,
    output logic [N_PT-1:0][ROW_W-1:0]    fuse_rows,
    output mc_mode_t [N_MC-1:0]           mc_mode,
    output logic [CSEL_W-1:0]             clk_sel
);
    logic [MODE_USED-1:0] mode_row;

    // Row write port: fuse rows, then the mode row at the next address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fuse_rows <= '0;
            mode_row  <= '0;
        end else if (cfg_load) begin
            if (cfg_addr < ADDR_W'(N_PT))
                fuse_rows[cfg_addr] <= cfg_data;
            else if (cfg_addr == ADDR_W'(MODE_ROW))
                mode_row <= cfg_data[MODE_USED-1:0];
        end
    end

    for (genvar m = 0; m < N_MC; m++) begin : g_mode
        assign mc_mode[m] = mc_mode_t'(mode_row[m*MC_MODE_W +: MC_MODE_W]);
    end
    assign clk_sel = mode_row[CSEL_LSB +: CSEL_W];

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> ($stable(fuse_rows) && $stable(mode_row)));
endmodule

// File: rtl/glb_and_array.sv
// Module glb_and_array: one product term per fuse row.
// Each term is the AND of its enabled true and complement literals.
// A row with no enabled literal is switched off and gives 0.
module glb_and_array
    import glb_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_IN-1:0]            lgc_in,
    input  logic [N_PT-1:0][ROW_W-1:0] fuse_rows,
    output logic [N_PT-1:0]            pt
);
    for (genvar p = 0; p < N_PT; p++) begin : g_pt
        logic [N_IN-1:0] use_t;
        logic [N_IN-1:0] use_c;

        // Split the row into true-literal and complement-literal masks.
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                use_t[i] = fuse_rows[p][2*i];
                use_c[i] = fuse_rows[p][2*i+1];
            end
        end

        assign pt[p] = (|fuse_rows[p]) & (&(~use_t | lgc_in)) & (&(~use_c | ~lgc_in));

        assert_empty_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (fuse_rows[p] == '0) |-> !pt[p]);
    end
endmodule

// File: rtl/glb_clk_sel.sv
// Module glb_clk_sel: chooses the block's register clock and finds its rising edge.
// It picks a global line or the product-term clock, then reports a rising edge
// as a one-cycle load pulse.
// Assumes every source is already synchronous to clk.
module glb_clk_sel
    import glb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              clk_pt,
    input  logic [CSEL_W-1:0] clk_sel,
    output logic              ld_edge
);
    logic src;
    logic src_d;

    // Source multiplexer: global lines first, product-term clock above them.
    always_comb begin
        if (int'(clk_sel) < N_GCLK) src = gclk[clk_sel];
        else                        src = clk_pt;
    end

    // Previous-cycle copy of the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) src_d <= 1'b0;
        else        src_d <= src;
    end

    assign ld_edge = src & ~src_d;

    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_edge |=> !ld_edge);
endmodule

// File: rtl/glb_macrocell.sv
// Module glb_macrocell: picks the bypass or wide sum and holds the register.
// It drives either the data value or the register at the output.
// Reset order: global reset, then the reset term, then the clocked load.
module glb_macrocell (
    input  logic clk,
    input  logic rst_n,
    input  logic grst_n,
    input  logic pt_rst,
    input  logic ld_edge,
    input  logic own_sum,
    input  logic wide_sum,
    input  logic xor_term,
    input  logic wide,
    input  logic reg_en,
    output logic mc_out
);
    logic d;
    logic q;

    // Data value: four-term bypass, or shared sum XOR the per-cell term.
    always_comb begin
        if (wide) d = wide_sum ^ xor_term;
        else      d = own_sum;
    end

    // Macrocell register with prioritised resets.
    always_ff @(posedge clk) begin
        if (!rst_n || !grst_n) q <= 1'b0;
        else if (pt_rst)       q <= 1'b0;
        else if (ld_edge)      q <= d;
    end

    assign mc_out = reg_en ? q : d;

    assert_grst_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !grst_n |=> !q);
    assert_ptrst_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grst_n && pt_rst) |=> !q);
    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grst_n && !pt_rst && ld_edge) |=> (q == $past(d)));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grst_n && !pt_rst && !ld_edge) |=> $stable(q));
endmodule

// File: rtl/glb_block.sv
// Module glb_block: top of the four-macrocell logic block.
// It joins the configuration store, the AND array, the clock selection and
// the macrocells.
// Assumes all inputs are synchronous to clk.
module glb_block
    import glb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grst_n,
    input  logic                cfg_load,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [ROW_W-1:0]    cfg_data,
    input  logic [N_GCLK-1:0]   gclk,
    input  logic [N_IN-1:0]     lgc_in,
    output logic [N_MC-1:0]     mc_out,
    output logic                pt_oe
);
    logic [N_PT-1:0][ROW_W-1:0] fuse_rows;
    mc_mode_t [N_MC-1:0]        mc_mode;
    logic [CSEL_W-1:0]          clk_sel;
    logic [N_PT-1:0]            pt;
    logic [N_MC-1:0]            cluster_or;
    logic [N_MC-1:0]            wide_sum;
    logic                       ld_edge;

    glb_cfg_store u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .fuse_rows(fuse_rows), .mc_mode(mc_mode), .clk_sel(clk_sel)
    );

    glb_and_array u_arr (
        .clk(clk), .rst_n(rst_n), .lgc_in(lgc_in), .fuse_rows(fuse_rows), .pt(pt)
    );

    glb_clk_sel u_clk (
        .clk(clk), .rst_n(rst_n), .gclk(gclk), .clk_pt(pt[CLK_PT]),
        .clk_sel(clk_sel), .ld_edge(ld_edge)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        assign cluster_or[m] = |pt[m*PT_PER_MC +: PT_PER_MC];
        assign wide_sum[m]   = |(cluster_or & mc_mode[m].share);

        glb_macrocell u_mc (
            .clk(clk), .rst_n(rst_n), .grst_n(grst_n), .pt_rst(pt[RST_PT]),
            .ld_edge(ld_edge), .own_sum(cluster_or[m]), .wide_sum(wide_sum[m]),
            .xor_term(pt[XOR_PT0+m]), .wide(mc_mode[m].wide),
            .reg_en(mc_mode[m].reg_en), .mc_out(mc_out[m])
        );
    end

    assign pt_oe = pt[OE_PT];
endmodule

// File: tb/sim_glb_block.sv
module sim_glb_block;
    logic        clk = 1'b0;
    logic        rst_n, grst_n, cfg_load;
    logic [4:0]  cfg_addr;
    logic [35:0] cfg_data;
    logic [2:0]  gclk;
    logic [17:0] lgc_in;
    logic [3:0]  mc_out;
    logic        pt_oe;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    int unsigned seed_dummy;

    logic [35:0] sh_row [0:22];
    logic [35:0] sh_mode;

    always #10 clk = ~clk;

    glb_block u0 (
        .clk(clk), .rst_n(rst_n), .grst_n(grst_n), .cfg_load(cfg_load),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .gclk(gclk),
        .lgc_in(lgc_in), .mc_out(mc_out), .pt_oe(pt_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [35:0] lit_t(input int i);
        return 36'(1) << (2 * i);
    endfunction
    function automatic logic [35:0] lit_c(input int i);
        return 36'(1) << (2 * i + 1);
    endfunction

    function automatic logic pt_ref(input logic [35:0] row, input logic [17:0] x);
        logic any = 1'b0;
        logic res = 1'b1;
        for (int i = 0; i < 18; i++) begin
            if (row[2*i])   begin any = 1'b1; res &= x[i];  end
            if (row[2*i+1]) begin any = 1'b1; res &= ~x[i]; end
        end
        return any & res;
    endfunction

    function automatic logic data_ref(input int m, input logic [17:0] x);
        logic [3:0] grp;
        logic [3:0] share;
        for (int k = 0; k < 4; k++)
            grp[k] = pt_ref(sh_row[4*k], x) | pt_ref(sh_row[4*k+1], x) |
                     pt_ref(sh_row[4*k+2], x) | pt_ref(sh_row[4*k+3], x);
        share = sh_mode[6*m+2 +: 4];
        if (sh_mode[6*m+1]) return (|(grp & share)) ^ pt_ref(sh_row[16+m], x);
        return grp[m];
    endfunction

    task automatic clear_shadow();
        for (int r = 0; r < 23; r++) sh_row[r] = '0;
        sh_mode = '0;
    endtask

    task automatic set_mode(input int m, input logic reg_en, input logic wide, input logic [3:0] share);
        sh_mode[6*m +: 6] = {share, wide, reg_en};
    endtask

    task automatic write_cfg(input logic [4:0] a, input logic [35:0] d);
        @(negedge clk);
        cfg_load = 1'b1; cfg_addr = a; cfg_data = d;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic load_all();
        for (int r = 0; r < 23; r++) write_cfg(5'(r), sh_row[r]);
        write_cfg(5'd23, sh_mode);
    endtask

    task automatic grst_pulse();
        @(negedge clk); grst_n = 1'b0;
        @(negedge clk); grst_n = 1'b1;
    endtask

    task automatic pulse_gclk(input int k);
        @(negedge clk); gclk[k] = 1'b1;
        @(negedge clk); gclk[k] = 1'b0;
        @(negedge clk);
    endtask

    // One counter step: feed back the state, then one rising edge on global clock 0.
    task automatic cnt_step();
        @(negedge clk); lgc_in[3:0] = mc_out; gclk[0] = 1'b1;
        @(negedge clk); gclk[0] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [3:0] exp4;
        int cnt;
        seed_dummy = $urandom(32'h5eed);
        rst_n = 1'b0; grst_n = 1'b1; cfg_load = 1'b0; cfg_addr = '0; cfg_data = '0;
        gclk = '0; lgc_in = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {27'd0, pt_oe, mc_out}, 32'd0);
        rst_n = 1'b1;

        // Decoder: out m = (en && sel == m) XOR invert, with en=in6, sel=in5:4, invert=in7.
        clear_shadow();
        for (int m = 0; m < 4; m++) begin
            sh_row[4*m] = lit_t(6) | (m[0] ? lit_t(4) : lit_c(4)) | (m[1] ? lit_t(5) : lit_c(5));
            sh_row[16+m] = lit_t(7);
            set_mode(m, 1'b0, 1'b1, 4'(1 << m));
        end
        load_all();
        for (int v = 0; v < 32; v++) begin
            @(negedge clk);
            lgc_in = 18'($urandom);
            if (v < 16) lgc_in[7:4] = 4'(v);
            #2;
            for (int m = 0; m < 4; m++)
                exp4[m] = (lgc_in[6] && (lgc_in[5:4] == 2'(m))) ^ lgc_in[7];
            chk("R3 R4 decoder", {28'd0, mc_out}, {28'd0, exp4});
        end

        // R9: writes without strobe and to unused addresses change nothing.
        @(negedge clk);
        lgc_in = '0; lgc_in[7] = 1'b1;
        cfg_load = 1'b0; cfg_addr = 5'd16; cfg_data = '0;
        repeat (2) @(negedge clk);
        chk("R9 no strobe", {28'd0, mc_out}, 32'hF);
        write_cfg(5'd24, 36'hF_FFFF_FFFF);
        write_cfg(5'd31, '0);
        #2;
        chk("R9 unused address", {28'd0, mc_out}, 32'hF);

        // R10: block reset clears the configuration.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #2;
        chk("R10 config cleared", {28'd0, mc_out}, 32'd0);

        // Random combinational configurations against the reference model.
        for (int c = 0; c < 8; c++) begin
            clear_shadow();
            for (int r = 0; r < 23; r++) begin
                if ($urandom % 4 != 0) begin
                    int nl;
                    nl = 1 + int'($urandom % 3);
                    for (int l = 0; l < nl; l++) begin
                        int i;
                        i = int'($urandom % 18);
                        sh_row[r] |= ($urandom % 2 != 0) ? lit_t(i) : lit_c(i);
                    end
                end
            end
            for (int m = 0; m < 4; m++)
                set_mode(m, 1'b0, (c == 0) ? 1'b0 : ((c == 1) ? 1'b1 : 1'($urandom)), 4'($urandom));
            load_all();
            for (int v = 0; v < 24; v++) begin
                @(negedge clk);
                lgc_in = 18'($urandom);
                #2;
                for (int m = 0; m < 4; m++) exp4[m] = data_ref(m, lgc_in);
                chk("R1 R2 R3 random array", {28'd0, mc_out}, {28'd0, exp4});
                chk("R8 output enable", {31'd0, pt_oe}, {31'd0, pt_ref(sh_row[22], lgc_in)});
            end
        end

        // 4-bit counter on global clock 0: bit0 toggles, bit m flips when lower bits all set.
        clear_shadow();
        sh_row[0] = lit_c(0);
        set_mode(0, 1'b1, 1'b0, 4'd0);
        for (int m = 1; m < 4; m++) begin
            sh_row[4*m] = lit_t(m);
            for (int j = 0; j < m; j++) sh_row[16+m] |= lit_t(j);
            set_mode(m, 1'b1, 1'b1, 4'(1 << m));
        end
        lgc_in = '0;
        load_all();
        grst_pulse();
        chk("R6 global reset", {28'd0, mc_out}, 32'd0);
        cnt = 0;
        for (int s = 0; s < 20; s++) begin
            cnt_step();
            cnt = (cnt + 1) % 16;
            chk("R5 R4 counter", {28'd0, mc_out}, 32'(cnt));
            if (s == 5) begin
                grst_pulse();
                cnt = 0;
                chk("R6 global reset mid count", {28'd0, mc_out}, 32'd0);
            end
        end
        // Global reset in the same cycle as a clock edge wins.
        @(negedge clk); lgc_in[3:0] = mc_out; gclk[0] = 1'b1; grst_n = 1'b0;
        @(negedge clk); gclk[0] = 1'b0; grst_n = 1'b1;
        chk("R6 reset beats load", {28'd0, mc_out}, 32'd0);

        // Clock selection, product-term clock, reset term, output enable.
        clear_shadow();
        sh_row[0]  = lit_t(8);
        sh_row[20] = lit_t(17);
        sh_row[21] = lit_t(16);
        sh_row[22] = lit_t(9) | lit_c(10);
        set_mode(0, 1'b1, 1'b0, 4'd0);
        sh_mode[25:24] = 2'd1;
        lgc_in = '0;
        load_all();
        grst_pulse();
        @(negedge clk); lgc_in[8] = 1'b1;
        pulse_gclk(0);
        pulse_gclk(2);
        @(negedge clk); lgc_in[17] = 1'b1;
        @(negedge clk); lgc_in[17] = 1'b0;
        @(negedge clk);
        chk("R5 unselected sources", {28'd0, mc_out}, 32'd0);
        pulse_gclk(1);
        chk("R5 selected line 1", {28'd0, mc_out}, 32'd1);

        @(negedge clk); lgc_in[8] = 1'b0;
        sh_mode[25:24] = 2'd3;
        write_cfg(5'd23, sh_mode);
        pulse_gclk(1);
        chk("R5 line 1 deselected", {28'd0, mc_out}, 32'd1);
        @(negedge clk); lgc_in[17] = 1'b1;
        @(negedge clk);
        chk("R5 term clock load", {28'd0, mc_out}, 32'd0);
        lgc_in[8] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 held clock no reload", {28'd0, mc_out}, 32'd0);
        lgc_in[17] = 1'b0;
        @(negedge clk); lgc_in[17] = 1'b1;
        @(negedge clk);
        chk("R5 term clock second edge", {28'd0, mc_out}, 32'd1);
        lgc_in[17] = 1'b0;
        @(negedge clk); lgc_in[16] = 1'b1;
        @(negedge clk); lgc_in[16] = 1'b0;
        chk("R7 reset term clears", {28'd0, mc_out}, 32'd0);
        @(negedge clk); lgc_in[16] = 1'b1; lgc_in[17] = 1'b1;
        @(negedge clk);
        chk("R7 reset term beats load", {28'd0, mc_out}, 32'd0);
        lgc_in[16] = 1'b0; lgc_in[17] = 1'b0;
        @(negedge clk); lgc_in[17] = 1'b1;
        @(negedge clk);
        chk("R5 load after reset term", {28'd0, mc_out}, 32'd1);

        for (int v = 0; v < 4; v++) begin
            @(negedge clk);
            lgc_in[10:9] = 2'(v);
            #2;
            chk("R8 enable term", {31'd0, pt_oe}, {31'd0, (v == 1) ? 1'b1 : 1'b0});
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule